// File: doc/BRIEF.md
# Filtered Longest-Prefix Lookup Controller

This block resolves the longest stored prefix that covers a destination address. All prefix lengths share one store made of two small hashed tables, a left one and a right one. Each table holds a row of buckets with a fixed number of entries per bucket. A bit-vector membership filter sits in front of the store. A lookup visits the prefix lengths one per cycle, from the longest to the shortest. Each visit hashes the address truncated to that length. Lengths that hold no stored prefix are skipped. A length is queried in the filter, and the two candidate buckets are read only when the filter answers positive. The scan ends at the first entry that really matches. If no entry matches, the result supplied by an external overflow matcher is returned.

The overflow matcher's answer (hit, length, next hop) is presented together with the start pulse. No table length at or below the overflow length can beat that answer, so the scan stops above it. Prefixes are added one per cycle while the controller is idle. Each one goes to whichever of its two candidate buckets is less occupied. When both candidate buckets are full, the prefix is handed back to the overflow matcher. The controller returns the count of filter queries and of table probes with every result, which shows how much table traffic the filter saved.

Top module: `lpm_lookup`

## Requirements
- R1: A per-length bitmap records which lengths 1..ADDR_W hold at least one table-resident prefix. Only marked lengths are queried in the filter. `res_queries` equals the number of marked lengths visited.
- R2: The scan starts at length ADDR_W. It ends after length `ovf_len`+1 when `ovf_hit` is set, and after length 1 otherwise. `ovf_hit`, `ovf_len`, `ovf_nh` and `lu_addr` are captured on the start cycle. With `ovf_hit`=1 and `ovf_len`=ADDR_W, nothing is queried.
- R3: The hash key for length l is the top l address bits, fed MSB first into an 8-bit CRC. The CRC uses polynomial 0x07 and starts from zero. The filter indices are CRC[7:4] and CRC[3:0], and a positive needs both filter bits set. A negative reads no table. `res_probes` equals the number of positives.
- R4: A positive whose two buckets hold no valid entry with the same length and the same masked prefix is a false positive, and the scan moves on to the next shorter length.
- R5: The first true match ends the scan. It reports `res_found`=1, `res_from_table`=1, the matched length and the stored next hop.
- R6: Without a table match, the result is `res_found`=`ovf_hit`, `res_from_table`=0, with length and next hop from the overflow inputs, or both zero when `ovf_hit`=0.
- R7: On insert, the left bucket index is CRC[7:5] and the right bucket index is CRC[2:0]. The prefix goes to the bucket holding fewer entries, and a tie goes left. One cycle later `ins_ack` pulses with `ins_side` (0 left, 1 right).
- R8: When both candidate buckets are full, `ins_to_ovf` pulses with `ins_ack`. The prefix is not stored, and neither the filter nor the length bitmap changes.
- R9: `busy` rises the cycle after an accepted `lu_start` and stays high until `done`. `done` is a one-cycle pulse with `busy` low. The result outputs hold until the next start.
- R10: `res_queries` and `res_probes` are valid in the `done` cycle and count only the lookup just finished.
- R11: An insert is ignored while `busy` is high or when `lu_start` is high in the same cycle. A `lu_start` while busy is ignored.
- R12: After reset the tables, filter and bitmap are empty, `busy`, `done` and `ins_ack` are low, and a lookup queries nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Insert request |
| ins_prefix | input | ADDR_W | Prefix value, MSB-aligned |
| ins_len | input | LEN_W | Prefix length 1..ADDR_W |
| ins_nh | input | NH_W | Next hop to store |
| ins_ack | output | 1 | Insert accepted (one cycle later) |
| ins_to_ovf | output | 1 | Insert handed to the overflow matcher |
| ins_side | output | 1 | Table chosen: 0 left, 1 right |
| lu_start | input | 1 | Start a lookup |
| lu_addr | input | ADDR_W | Destination address |
| ovf_hit | input | 1 | Overflow matcher found a prefix |
| ovf_len | input | LEN_W | Length of the overflow match |
| ovf_nh | input | NH_W | Next hop of the overflow match |
| busy | output | 1 | Lookup in progress |
| done | output | 1 | One-cycle result strobe |
| res_found | output | 1 | A prefix was found |
| res_from_table | output | 1 | The result came from the hashed store |
| res_len | output | LEN_W | Length of the best match |
| res_nh | output | NH_W | Next hop of the best match |
| res_queries | output | LEN_W | Filter queries in this lookup |
| res_probes | output | LEN_W | Table probes in this lookup |

## Verification
On every cycle, the assertions check the busy/done handshake, that probes never outnumber queries, that a busy controller acknowledges no insert, and that each insert acknowledgement agrees with the bucket occupancies seen when it was accepted. Which prefix wins is a different matter. So are the exact counts of queries and probes, the effect of the length bitmap and the overflow floor on the scan, and the ignoring of requests while busy. Only the bench's scenarios can show these, because they depend on the stored contents. The bench compares every address of the small configuration, with and without overflow results, against its own model of the hashed store.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } scan_state_e;

  localparam logic SIDE_LEFT  = 1'b0;
  localparam logic SIDE_RIGHT = 1'b1;

endpackage

// File: rtl/lpm_hash.sv
// Serial CRC over the top `len` bits of `key`, sliced into filter and table indices.
module lpm_hash #(
  parameter int KEY_W    = 8,
  parameter int LEN_W    = 4,
  parameter int CRC_W    = 8,
  parameter logic [CRC_W-1:0] POLY = 8'h07,
  parameter int BF_IDX_W = 4,
  parameter int TB_IDX_W = 3
) (
  input  logic [KEY_W-1:0]               key,
  input  logic [LEN_W-1:0]               len,
  output logic [1:0][BF_IDX_W-1:0]       bf_idx,
  output logic [1:0][TB_IDX_W-1:0]       tb_idx
);

  function automatic logic [CRC_W-1:0] crc_serial(input logic [KEY_W-1:0] k,
                                                  input logic [LEN_W-1:0] l);
    logic [CRC_W-1:0] c;
    logic fb;
    c = '0;
    for (int i = 0; i < KEY_W; i++) begin
      if (i < int'(l)) begin
        fb = c[CRC_W-1] ^ k[KEY_W-1-i];
        c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
      end
    end
    return c;
  endfunction

  logic [CRC_W-1:0] code;

  always_comb begin
    code      = crc_serial(key, len);
    bf_idx[0] = code[CRC_W-1 -: BF_IDX_W];
    bf_idx[1] = code[BF_IDX_W-1:0];
    tb_idx[0] = code[CRC_W-1 -: TB_IDX_W];
    tb_idx[1] = code[TB_IDX_W-1:0];
  end

endmodule

// File: rtl/lpm_bloom.sv
// Membership bit vector: set all indexed bits on program, AND them on query.
module lpm_bloom #(
  parameter int IDX_W   = 4,
  parameter int NUM_IDX = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          set_en,
  input  logic [NUM_IDX-1:0][IDX_W-1:0] set_idx,
  input  logic [NUM_IDX-1:0][IDX_W-1:0] qry_idx,
  output logic                          qry_pos
);

  localparam int BITS = 1 << IDX_W;

  logic [BITS-1:0]    bits_q;
  logic [NUM_IDX-1:0] probe_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
    end else if (set_en) begin
      for (int i = 0; i < NUM_IDX; i++) bits_q[set_idx[i]] <= 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_IDX; g++) begin : g_probe
    assign probe_bit[g] = bits_q[qry_idx[g]];
  end

  assign qry_pos = &probe_bit;

endmodule

// File: rtl/lpm_side.sv
// One hashed table: BUCKETS x ENTRIES slots, write to first free slot, parallel bucket compare.
module lpm_side #(
  parameter int ADDR_W  = 8,
  parameter int LEN_W   = 4,
  parameter int NH_W    = 8,
  parameter int IDX_W   = 3,
  parameter int ENTRIES = 2,
  parameter int OCC_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [LEN_W-1:0]  wr_len,
  input  logic [ADDR_W-1:0] wr_key,
  input  logic [NH_W-1:0]   wr_nh,
  output logic [OCC_W-1:0]  occ,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [LEN_W-1:0]  rd_len,
  input  logic [ADDR_W-1:0] rd_key,
  output logic              rd_hit,
  output logic [NH_W-1:0]   rd_nh
);

  localparam int BUCKETS = 1 << IDX_W;
  localparam int SLOT_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic              ent_v   [BUCKETS][ENTRIES];
  logic [LEN_W-1:0]  ent_len [BUCKETS][ENTRIES];
  logic [ADDR_W-1:0] ent_key [BUCKETS][ENTRIES];
  logic [NH_W-1:0]   ent_nh  [BUCKETS][ENTRIES];

  logic [SLOT_W-1:0] free_slot;
  logic              has_free;

  always_comb begin
    occ       = '0;
    free_slot = '0;
    has_free  = 1'b0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (ent_v[wr_idx][e]) begin
        occ = occ + OCC_W'(1);
      end else if (!has_free) begin
        has_free  = 1'b1;
        free_slot = SLOT_W'(e);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < BUCKETS; b++) begin
        for (int e = 0; e < ENTRIES; e++) begin
          ent_v[b][e]   <= 1'b0;
          ent_len[b][e] <= '0;
          ent_key[b][e] <= '0;
          ent_nh[b][e]  <= '0;
        end
      end
    end else if (wr_en && has_free) begin
      ent_v[wr_idx][free_slot]   <= 1'b1;
      ent_len[wr_idx][free_slot] <= wr_len;
      ent_key[wr_idx][free_slot] <= wr_key;
      ent_nh[wr_idx][free_slot]  <= wr_nh;
    end
  end

  always_comb begin
    rd_hit = 1'b0;
    rd_nh  = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (!rd_hit && ent_v[rd_idx][e] && ent_len[rd_idx][e] == rd_len &&
          ent_key[rd_idx][e] == rd_key) begin
        rd_hit = 1'b1;
        rd_nh  = ent_nh[rd_idx][e];
      end
    end
  end

endmodule

// File: rtl/lpm_lookup.sv
module lpm_lookup
  import lpm_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NH_W     = 8,
  parameter int CRC_W    = 8,
  parameter logic [CRC_W-1:0] CRC_POLY = 8'h07,
  parameter int BF_IDX_W = 4,
  parameter int TB_IDX_W = 3,
  parameter int ENTRIES  = 2,
  localparam int LEN_W   = $clog2(ADDR_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  input  logic [ADDR_W-1:0] ins_prefix,
  input  logic [LEN_W-1:0]  ins_len,
  input  logic [NH_W-1:0]   ins_nh,
  output logic              ins_ack,
  output logic              ins_to_ovf,
  output logic              ins_side,
  input  logic              lu_start,
  input  logic [ADDR_W-1:0] lu_addr,
  input  logic              ovf_hit,
  input  logic [LEN_W-1:0]  ovf_len,
  input  logic [NH_W-1:0]   ovf_nh,
  output logic              busy,
  output logic              done,
  output logic              res_found,
  output logic              res_from_table,
  output logic [LEN_W-1:0]  res_len,
  output logic [NH_W-1:0]   res_nh,
  output logic [LEN_W-1:0]  res_queries,
  output logic [LEN_W-1:0]  res_probes
);

  localparam int CNT_W = LEN_W;
  localparam int OCC_W = $clog2(ENTRIES + 1);

  function automatic logic [ADDR_W-1:0] len_mask(input logic [LEN_W-1:0] l);
    logic [ADDR_W-1:0] m;
    m = '0;
    for (int i = 0; i < ADDR_W; i++) begin
      if (i < int'(l)) m[ADDR_W-1-i] = 1'b1;
    end
    return m;
  endfunction

  scan_state_e       state_q;
  logic [LEN_W-1:0]  cur_len_q, floor_q, ovf_len_q;
  logic [ADDR_W-1:0] addr_q;
  logic              ovf_hit_q;
  logic [NH_W-1:0]   ovf_nh_q;
  logic [CNT_W-1:0]  q_cnt_q, p_cnt_q;
  logic [ADDR_W:0]   len_valid_q;

  logic [ADDR_W-1:0] ins_key, lk_key;
  logic [1:0][BF_IDX_W-1:0] in_bf_idx, lk_bf_idx;
  logic [1:0][TB_IDX_W-1:0] in_tb_idx, lk_tb_idx;

  logic [1:0]              side_wr_en;
  logic [1:0][OCC_W-1:0]   side_occ;
  logic [1:0]              side_hit;
  logic [1:0][NH_W-1:0]    side_nh;

  // Named internal events for the checker
  logic ins_fire, to_ovf, pick_side, store_en;
  logic [OCC_W-1:0] occ_l, occ_r;
  logic scan_active, at_floor, len_ok, query_fire, bf_pos, probe_fire, tbl_match, finish;

  assign ins_key = ins_prefix & len_mask(ins_len);
  assign lk_key  = addr_q & len_mask(cur_len_q);

  lpm_hash #(.KEY_W(ADDR_W), .LEN_W(LEN_W), .CRC_W(CRC_W), .POLY(CRC_POLY),
             .BF_IDX_W(BF_IDX_W), .TB_IDX_W(TB_IDX_W)) u_hash_ins (
    .key(ins_key), .len(ins_len), .bf_idx(in_bf_idx), .tb_idx(in_tb_idx));

  lpm_hash #(.KEY_W(ADDR_W), .LEN_W(LEN_W), .CRC_W(CRC_W), .POLY(CRC_POLY),
             .BF_IDX_W(BF_IDX_W), .TB_IDX_W(TB_IDX_W)) u_hash_lk (
    .key(lk_key), .len(cur_len_q), .bf_idx(lk_bf_idx), .tb_idx(lk_tb_idx));

  lpm_bloom #(.IDX_W(BF_IDX_W), .NUM_IDX(2)) u_bloom (
    .clk(clk), .rst_n(rst_n), .set_en(store_en), .set_idx(in_bf_idx),
    .qry_idx(lk_bf_idx), .qry_pos(bf_pos));

  for (genvar s = 0; s < 2; s++) begin : g_side
    lpm_side #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .NH_W(NH_W), .IDX_W(TB_IDX_W),
               .ENTRIES(ENTRIES), .OCC_W(OCC_W)) u_side (
      .clk(clk), .rst_n(rst_n),
      .wr_en(side_wr_en[s]), .wr_idx(in_tb_idx[s]), .wr_len(ins_len),
      .wr_key(ins_key), .wr_nh(ins_nh), .occ(side_occ[s]),
      .rd_idx(lk_tb_idx[s]), .rd_len(cur_len_q), .rd_key(lk_key),
      .rd_hit(side_hit[s]), .rd_nh(side_nh[s]));
  end

  // Insert: least-loaded candidate bucket, ties to the left table
  always_comb begin
    occ_l      = side_occ[0];
    occ_r      = side_occ[1];
    ins_fire   = ins_valid && (state_q == ST_IDLE) && !lu_start &&
                 (ins_len != '0) && (ins_len <= LEN_W'(ADDR_W));
    to_ovf     = (occ_l == OCC_W'(ENTRIES)) && (occ_r == OCC_W'(ENTRIES));
    pick_side  = (occ_l <= occ_r) ? SIDE_LEFT : SIDE_RIGHT;
    store_en   = ins_fire && !to_ovf;
    side_wr_en = {store_en && (pick_side == SIDE_RIGHT),
                  store_en && (pick_side == SIDE_LEFT)};
  end

  // Scan step: one length per cycle
  always_comb begin
    scan_active = (state_q == ST_SCAN);
    at_floor    = (cur_len_q <= floor_q);
    len_ok      = len_valid_q[cur_len_q];
    query_fire  = scan_active && !at_floor && len_ok;
    probe_fire  = query_fire && bf_pos;
    tbl_match   = probe_fire && (side_hit[0] || side_hit[1]);
    finish      = scan_active && (at_floor || tbl_match);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q        <= ST_IDLE;
      cur_len_q      <= '0;
      floor_q        <= '0;
      addr_q         <= '0;
      ovf_hit_q      <= 1'b0;
      ovf_len_q      <= '0;
      ovf_nh_q       <= '0;
      q_cnt_q        <= '0;
      p_cnt_q        <= '0;
      len_valid_q    <= '0;
      ins_ack        <= 1'b0;
      ins_to_ovf     <= 1'b0;
      ins_side       <= SIDE_LEFT;
      done           <= 1'b0;
      res_found      <= 1'b0;
      res_from_table <= 1'b0;
      res_len        <= '0;
      res_nh         <= '0;
      res_queries    <= '0;
      res_probes     <= '0;
    end else begin
      done       <= 1'b0;
      ins_ack    <= ins_fire;
      ins_to_ovf <= ins_fire && to_ovf;
      ins_side   <= store_en ? pick_side : SIDE_LEFT;
      if (store_en) len_valid_q[ins_len] <= 1'b1;

      case (state_q)
        ST_IDLE: begin
          if (lu_start) begin
            state_q   <= ST_SCAN;
            addr_q    <= lu_addr;
            cur_len_q <= LEN_W'(ADDR_W);
            floor_q   <= ovf_hit ? ovf_len : '0;
            ovf_hit_q <= ovf_hit;
            ovf_len_q <= ovf_len;
            ovf_nh_q  <= ovf_nh;
            q_cnt_q   <= '0;
            p_cnt_q   <= '0;
          end
        end
        ST_SCAN: begin
          if (query_fire) q_cnt_q <= q_cnt_q + CNT_W'(1);
          if (probe_fire) p_cnt_q <= p_cnt_q + CNT_W'(1);
          if (finish) begin
            state_q     <= ST_IDLE;
            done        <= 1'b1;
            res_queries <= q_cnt_q + CNT_W'(query_fire);
            res_probes  <= p_cnt_q + CNT_W'(probe_fire);
            if (tbl_match) begin
              res_found      <= 1'b1;
              res_from_table <= 1'b1;
              res_len        <= cur_len_q;
              res_nh         <= side_hit[0] ? side_nh[0] : side_nh[1];
            end else begin
              res_found      <= ovf_hit_q;
              res_from_table <= 1'b0;
              res_len        <= ovf_hit_q ? ovf_len_q : '0;
              res_nh         <= ovf_hit_q ? ovf_nh_q : '0;
            end
          end else begin
            cur_len_q <= cur_len_q - LEN_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state_q == ST_SCAN);

endmodule

// File: rtl/lpm_lookup_chk.sv
module lpm_lookup_chk #(
  parameter int CNT_W   = 4,
  parameter int OCC_W   = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lu_start,
  input logic             busy,
  input logic             done,
  input logic             res_found,
  input logic             res_from_table,
  input logic [CNT_W-1:0] res_queries,
  input logic [CNT_W-1:0] res_probes,
  input logic             ins_ack,
  input logic             ins_to_ovf,
  input logic             ins_side,
  input logic [OCC_W-1:0] occ_l,
  input logic [OCC_W-1:0] occ_r,
  input logic             ins_full
);

  // R9
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lu_start && !busy) |=> busy);

  // R3
  probe_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (res_probes <= res_queries));

  // R5
  table_found_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_from_table) |-> res_found);

  // R11
  busy_no_ins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !ins_ack);

  // R8
  ovf_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_ack && ins_to_ovf) |-> $past(ins_full));

  // R7
  right_lighter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_ack && !ins_to_ovf && ins_side) |-> ($past(occ_r) < $past(occ_l)));

  // R7
  left_tie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_ack && !ins_to_ovf && !ins_side) |-> ($past(occ_l) <= $past(occ_r)));

endmodule

bind lpm_lookup lpm_lookup_chk #(.CNT_W(CNT_W), .OCC_W(OCC_W)) u_lookup_chk (
  .clk(clk), .rst_n(rst_n), .lu_start(lu_start), .busy(busy), .done(done),
  .res_found(res_found), .res_from_table(res_from_table),
  .res_queries(res_queries), .res_probes(res_probes),
  .ins_ack(ins_ack), .ins_to_ovf(ins_to_ovf), .ins_side(ins_side),
  .occ_l(occ_l), .occ_r(occ_r), .ins_full(to_ovf));

// File: tb/lpm_lookup_test.sv
`timescale 1ns/1ps
module lpm_lookup_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ins_valid = 1'b0;
  logic [7:0] ins_prefix = '0;
  logic [3:0] ins_len = '0;
  logic [7:0] ins_nh = '0;
  logic       ins_ack, ins_to_ovf, ins_side;
  logic       lu_start = 1'b0;
  logic [7:0] lu_addr = '0;
  logic       ovf_hit = 1'b0;
  logic [3:0] ovf_len = '0;
  logic [7:0] ovf_nh = '0;
  logic       busy, done, res_found, res_from_table;
  logic [3:0] res_len, res_queries, res_probes;
  logic [7:0] res_nh;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  lpm_lookup uut (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_prefix(ins_prefix),
    .ins_len(ins_len), .ins_nh(ins_nh), .ins_ack(ins_ack), .ins_to_ovf(ins_to_ovf),
    .ins_side(ins_side), .lu_start(lu_start), .lu_addr(lu_addr), .ovf_hit(ovf_hit),
    .ovf_len(ovf_len), .ovf_nh(ovf_nh), .busy(busy), .done(done),
    .res_found(res_found), .res_from_table(res_from_table), .res_len(res_len),
    .res_nh(res_nh), .res_queries(res_queries), .res_probes(res_probes));

  // Reference model of the hashed store
  int m_n = 0;
  int m_len [64];
  int m_pfx [64];
  int m_nh  [64];
  int occ   [2][8];
  bit bfm   [16];
  bit vlen  [9];
  int a_n = 0;
  int a_len [64];
  int a_pfx [64];
  int n_ovf = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int mask_of(input int l);
    return (((1 << l) - 1) << (8 - l)) & 255;
  endfunction

  // CRC as the remainder of key * x^8 divided by x^8 + x^2 + x + 1
  function automatic int ref_crc(input int pfx, input int l);
    int r;
    r = (pfx >> (8 - l)) << 8;
    for (int pos = l + 7; pos >= 8; pos--) begin
      if (((r >> pos) & 1) == 1) r = r ^ (32'h107 << (pos - 8));
    end
    return r & 255;
  endfunction

  task automatic model_lookup(input int a, input bit oh, input int ol, input int onh,
                              output bit ef, output bit et, output int el, output int enh,
                              output int eq, output int ep);
    int flo, c;
    bit hit;
    flo = oh ? ol : 0;
    eq = 0; ep = 0; hit = 0; el = 0; enh = 0;
    for (int l = 8; l > flo && !hit; l--) begin
      if (vlen[l]) begin
        eq++;
        c = ref_crc(a & mask_of(l), l);
        if (bfm[c >> 4] && bfm[c & 15]) begin
          ep++;
          for (int i = 0; i < m_n; i++) begin
            if (!hit && m_len[i] == l && m_pfx[i] == (a & mask_of(l))) begin
              hit = 1; el = l; enh = m_nh[i];
            end
          end
        end
      end
    end
    et = hit;
    ef = hit ? 1'b1 : oh;
    if (!hit) begin
      el  = oh ? ol : 0;
      enh = oh ? onh : 0;
    end
  endtask

  task automatic wait_done();
    int cyc = 0;
    while (!done && cyc < 64) begin
      @(negedge clk);
      cyc++;
    end
    check(done == 1'b1, "R9", "done seen", done, 1);
  endtask

  task automatic compare_result(input int a, input bit oh, input int ol, input int onh);
    bit ef, et;
    int el, enh, eq, ep;
    string rq;
    model_lookup(a, oh, ol, onh, ef, et, el, enh, eq, ep);
    rq = et ? "R5" : "R6";
    check(res_found == ef, rq, $sformatf("found a=%0d", a), res_found, ef);
    check(res_from_table == et, (ep > int'(et)) ? "R4" : rq,
          $sformatf("from_table a=%0d", a), res_from_table, et);
    check(int'(res_len) == el, rq, $sformatf("len a=%0d", a), res_len, el);
    check(int'(res_nh) == enh, rq, $sformatf("nh a=%0d", a), res_nh, enh);
    check(int'(res_queries) == eq, "R1", $sformatf("queries a=%0d", a), res_queries, eq);
    check(int'(res_probes) == ep, "R3", $sformatf("probes a=%0d", a), res_probes, ep);
  endtask

  task automatic do_lookup(input int a, input bit oh, input int ol, input int onh);
    @(negedge clk);
    lu_start = 1'b1; lu_addr = a[7:0];
    ovf_hit = oh; ovf_len = ol[3:0]; ovf_nh = onh[7:0];
    @(negedge clk);
    lu_start = 1'b0;
    check(busy == 1'b1, "R9", "busy after start", busy, 1);
    wait_done();
    check(busy == 1'b0, "R9", "busy low with done", busy, 0);
    compare_result(a, oh, ol, onh);
    @(negedge clk);
    check(done == 1'b0, "R9", "done one cycle", done, 0);
    check(busy == 1'b0, "R10", "idle after result", busy, 0);
  endtask

  task automatic do_insert(input int l, input int p, input int nh);
    int c, i1, i2;
    bit eo, es;
    c  = ref_crc(p, l);
    i1 = c >> 5;
    i2 = c & 7;
    eo = (occ[0][i1] >= 2) && (occ[1][i2] >= 2);
    es = (occ[0][i1] <= occ[1][i2]) ? 1'b0 : 1'b1;
    @(negedge clk);
    ins_valid = 1'b1; ins_prefix = p[7:0]; ins_len = l[3:0]; ins_nh = nh[7:0];
    @(negedge clk);
    ins_valid = 1'b0;
    check(ins_ack == 1'b1, "R7", "ins_ack", ins_ack, 1);
    check(ins_to_ovf == eo, "R8", $sformatf("to_ovf p=%0d l=%0d", p, l), ins_to_ovf, eo);
    if (!eo) check(ins_side == es, "R7", $sformatf("side p=%0d l=%0d", p, l), ins_side, es);
    a_len[a_n] = l; a_pfx[a_n] = p; a_n++;
    if (eo) begin
      n_ovf++;
    end else begin
      occ[es][es ? i2 : i1]++;
      m_len[m_n] = l; m_pfx[m_n] = p; m_nh[m_n] = nh; m_n++;
      bfm[c >> 4] = 1'b1; bfm[c & 15] = 1'b1;
      vlen[l] = 1'b1;
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit dup;
    int l, p;
    for (int s = 0; s < 2; s++) for (int b = 0; b < 8; b++) occ[s][b] = 0;
    for (int i = 0; i < 16; i++) bfm[i] = 1'b0;
    for (int i = 0; i < 9; i++) vlen[i] = 1'b0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check(busy == 1'b0, "R12", "busy after reset", busy, 0);
    check(done == 1'b0, "R12", "done after reset", done, 0);
    check(ins_ack == 1'b0, "R12", "ins_ack after reset", ins_ack, 0);
    do_lookup(8'hA5, 1'b0, 0, 0);   // R12 empty store
    do_lookup(8'h3C, 1'b1, 2, 77);  // R6 overflow result only

    // R11: insert and second start while busy are ignored
    @(negedge clk);
    lu_start = 1'b1; lu_addr = 8'h5A; ovf_hit = 1'b0;
    @(negedge clk);
    lu_start = 1'b0;
    @(negedge clk);
    ins_valid = 1'b1; ins_prefix = 8'hC3; ins_len = 4'd8; ins_nh = 8'd9;
    lu_start = 1'b1; lu_addr = 8'h11; ovf_hit = 1'b1; ovf_len = 4'd3; ovf_nh = 8'd44;
    @(negedge clk);
    ins_valid = 1'b0; lu_start = 1'b0;
    check(ins_ack == 1'b0, "R11", "insert while busy", ins_ack, 0);
    wait_done();
    compare_result(8'h5A, 1'b0, 0, 0);
    @(negedge clk);
    // R11: insert together with a start is ignored
    ins_valid = 1'b1; ins_prefix = 8'hC3; ins_len = 4'd8; ins_nh = 8'd9;
    lu_start = 1'b1; lu_addr = 8'h22; ovf_hit = 1'b0;
    @(negedge clk);
    ins_valid = 1'b0; lu_start = 1'b0;
    check(ins_ack == 1'b0, "R11", "insert with start", ins_ack, 0);
    wait_done();
    @(negedge clk);
    do_lookup(8'hC3, 1'b0, 0, 0);   // R11: nothing stored, no queries

    // Fill the store with 40 distinct prefixes (32 slots, so some overflow)
    for (int i = 0; a_n < 40 && i < 400; i++) begin
      l = (i * 3) % 8 + 1;
      p = ((i * 73 + 29) & 255) & mask_of(l);
      dup = 0;
      for (int j = 0; j < a_n; j++) if (a_len[j] == l && a_pfx[j] == p) dup = 1;
      if (!dup) do_insert(l, p, (i % 250) + 1);
    end
    check(n_ovf > 0, "R8", "overflow inserts seen", n_ovf, 1);

    // R8: overflowed prefixes are absent from the store (covered by model)
    // Sweep every address without and with overflow results
    for (int a = 0; a < 256; a++) do_lookup(a, 1'b0, 0, 0);
    for (int a = 0; a < 256; a++) do_lookup(a, a[0], (a * 3) % 8 + 1, a ^ 8'h5A);
    // R2: overflow at full length leaves nothing to scan
    do_lookup(8'hFF, 1'b1, 8, 200);
    do_lookup(8'h00, 1'b1, 8, 201);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule